// File: doc/BRIEF.md
# Presettable Cascadable Binary Counter

This block is a synchronous binary up-counter. It can be preset from a parallel data input and has two count-enable inputs. Every state bit is registered on the same rising clock edge, so all bits of the count change together. A ripple-carry output lets several stages be chained into a wider synchronous counter. The carry of one stage drives the T enable of the next stage, and all stages share the clock and the P enable.

A build-time parameter selects how the active-low clear behaves. In the asynchronous style, the clear zeroes the count at once, whatever the clock is doing. In the synchronous style, the clear takes effect at the next rising edge and has priority over every other control. The load is also synchronous and overrides both enables. The counter advances only when P and T are both high. The carry depends on T and on the count alone, and P has no part in it.

Top module: `preset_counter`

## Requirements
- R1: The count changes only on a rising clock edge, except for an asynchronous clear. Changing load_n, en_p, en_t or din between edges leaves q unchanged until the next rising edge.
- R2: When load_n is low at a rising edge and no clear is in effect, q takes the value of din, whatever the levels of en_p and en_t.
- R3: With ASYNC_CLEAR=1, a low clr_n forces q to all zeros immediately. It holds q there while it stays low and overrides the clock, load_n and both enables.
- R4: With ASYNC_CLEAR=0, a low clr_n sampled at a rising edge sets q to all zeros at that edge. Between edges, clr_n has no effect on q.
- R5: When clr_n and load_n are both high and en_p and en_t are both high at a rising edge, q increases by one.
- R6: Counting from the maximum value (all ones, 4'b1111 at the default width) wraps q to all zeros.
- R7: When load_n is high and en_p or en_t is low at a rising edge, q holds its value. This includes the case where en_t is low and en_p is high.
- R8: carry is high exactly when en_t is high and q is all ones. It follows both inputs combinationally within the same cycle, and en_p has no effect on it.
- R9: At a rising edge, the controls take effect in this order: a synchronous clear first, then load, then count, then hold. With the synchronous style, a clear and a load at the same edge give zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on the rising edge |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous according to ASYNC_CLEAR |
| load_n | input | 1 | Active-low synchronous parallel preset |
| din | input | WIDTH | Preset value |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| q | output | WIDTH | Current count |
| carry | output | 1 | Ripple carry: high when en_t is high and q is all ones |

## Verification
Four behaviours are checked by properties on every clock edge:
- a load edge leaves q equal to the previous din;
- a count edge leaves q one higher, wrapping at the top;
- a hold edge leaves q unchanged;
- the carry is high only with T high and q at all ones.

Each clear style also has a property for the clear itself. Other behaviours can only be shown by the bench's timed scenarios:
- the immediate response of the asynchronous clear in the middle of a clock phase;
- the absence of any response between edges, including a synchronous clear that has not yet been clocked;
- the same-edge contest between clear and load.

// File: rtl/preset_counter_pkg.sv
package preset_counter_pkg;

    // Operation selected for the coming rising edge, lowest priority first.
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

endpackage

// File: rtl/cnt_mode_decode.sv
module cnt_mode_decode
    import preset_counter_pkg::*;
#(
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    en_p,
    input  logic    en_t,
    output cnt_op_e op
);

    // The clear is handled here only in the synchronous style; the asynchronous
    // style clears through the register's own reset path.
    always_comb begin
        if (!ASYNC_CLEAR && !clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (en_p && en_t) begin
            op = OP_COUNT;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
    import preset_counter_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  cnt_op_e          op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);

    localparam logic [WIDTH-1:0] ZERO = '0;
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
    } state_t;

    state_t s_d;
    state_t s_q;

    always_comb begin
        s_d = s_q;
        unique case (op)
            OP_CLEAR: s_d.count = ZERO;
            OP_LOAD:  s_d.count = din;
            OP_COUNT: s_d.count = s_q.count + ONE;
            default:  s_d.count = s_q.count;
        endcase
    end

    generate
        if (ASYNC_CLEAR) begin : g_async_clear
            always_ff @(posedge clk or negedge clr_n) begin
                if (!clr_n) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end

            AST_ASYNC_CLEAR_ZERO: assert property (@(posedge clk)
                !clr_n |-> (q == ZERO)); // R3
        end else begin : g_sync_clear
            always_ff @(posedge clk) begin
                s_q <= s_d;
            end

            AST_SYNC_CLEAR_ZERO: assert property (@(posedge clk)
                !clr_n |=> (q == ZERO)); // R4
        end
    endgenerate

    assign q = s_q.count;

    AST_LOAD_TAKES_DIN: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_LOAD) |=> (q == $past(din))); // R2

    AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_COUNT) |=> (q == WIDTH'($past(q) + ONE))); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!clr_n)
        (op == OP_HOLD) |=> $stable(q)); // R7

endmodule

// File: rtl/cnt_carry_decode.sv
module cnt_carry_decode #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             carry
);

    logic at_max;

    always_comb begin
        at_max = &q;
        carry  = at_max & en_t;
    end

    AST_CARRY_NEEDS_T: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> en_t); // R8

    AST_CARRY_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!clr_n)
        carry |-> (q == {WIDTH{1'b1}})); // R8

endmodule

// File: rtl/preset_counter.sv
module preset_counter
    import preset_counter_pkg::*;
#(
    parameter int WIDTH       = 4,
    parameter bit ASYNC_CLEAR = 1'b1
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             carry
);

    cnt_op_e op;

    cnt_mode_decode #(
        .ASYNC_CLEAR (ASYNC_CLEAR)
    ) u_decode (
        .clr_n  (clr_n),
        .load_n (load_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .op     (op)
    );

    cnt_state_reg #(
        .WIDTH       (WIDTH),
        .ASYNC_CLEAR (ASYNC_CLEAR)
    ) u_state (
        .clk   (clk),
        .clr_n (clr_n),
        .op    (op),
        .din   (din),
        .q     (q)
    );

    cnt_carry_decode #(
        .WIDTH (WIDTH)
    ) u_carry (
        .clk   (clk),
        .clr_n (clr_n),
        .q     (q),
        .en_t  (en_t),
        .carry (carry)
    );

    // Wrap from the top value (R6) is seen by the count property, whose sum is
    // truncated to WIDTH.
    AST_LOAD_BEATS_ENABLES: assert property (@(posedge clk) disable iff (!clr_n)
        (!load_n && en_p && en_t) |=> (q == $past(din))); // R9

endmodule

// File: tb/preset_counter_bench.sv
module preset_counter_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n;
    logic         load_n;
    logic [W-1:0] din;
    logic         en_p;
    logic         en_t;
    logic [W-1:0] qa;
    logic         ca;
    logic [W-1:0] qs;
    logic         cs;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    preset_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b1)) u_preset_counter (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(qa), .carry(ca)
    );

    preset_counter #(.WIDTH(W), .ASYNC_CLEAR(1'b0)) u_preset_counter_sync (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(qs), .carry(cs)
    );

    task automatic chk(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One rising edge, then settle at the falling edge for sampling.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic ld_n, input logic [W-1:0] d,
                         input logic p, input logic t);
        load_n = ld_n; din = d; en_p = p; en_t = t;
    endtask

    task automatic t_reset();
        clr_n = 1'b0;
        drive(1'b1, 4'h0, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R3", "async reset value", qa, 4'h0);
        chk("R4", "sync reset value", qs, 4'h0);
        chk("R8", "carry at reset", {3'b0, ca}, 4'h0);
    endtask

    task automatic t_load();
        clr_n = 1'b1;
        drive(1'b0, 4'h5, 1'b0, 1'b0);
        step();
        chk("R2", "load with enables low", qa, 4'h5);
        chk("R2", "load sync variant", qs, 4'h5);
        drive(1'b0, 4'hA, 1'b1, 1'b1);
        step();
        chk("R9", "load beats count", qa, 4'hA);
        chk("R9", "load beats count sync", qs, 4'hA);
    endtask

    task automatic t_count();
        drive(1'b0, 4'h3, 1'b0, 1'b0);
        step();
        drive(1'b1, 4'h0, 1'b1, 1'b1);
        repeat (3) step();
        chk("R5", "three counts from 3", qa, 4'h6);
        chk("R5", "three counts sync", qs, 4'h6);
    endtask

    task automatic t_wrap_carry();
        drive(1'b0, 4'hE, 1'b0, 1'b0);
        step();
        drive(1'b1, 4'h0, 1'b1, 1'b1);
        step();
        chk("R5", "count to top", qa, 4'hF);
        chk("R8", "carry at top with T", {3'b0, ca}, 4'h1);
        en_p = 1'b0;
        #1;
        chk("R8", "carry unaffected by P", {3'b0, ca}, 4'h1);
        step();
        chk("R7", "hold with P low", qa, 4'hF);
        en_t = 1'b0;
        #1;
        chk("R8", "carry drops with T", {3'b0, ca}, 4'h0);
        en_p = 1'b1;
        step();
        chk("R7", "hold with T low P high", qa, 4'hF);
        chk("R7", "hold sync variant", qs, 4'hF);
        en_t = 1'b1;
        #1;
        chk("R8", "carry rises with T same cycle", {3'b0, ca}, 4'h1);
        step();
        chk("R6", "wrap to zero", qa, 4'h0);
        chk("R6", "wrap sync variant", qs, 4'h0);
        chk("R8", "carry low after wrap", {3'b0, ca}, 4'h0);
    endtask

    task automatic t_between_edges();
        drive(1'b1, 4'h0, 1'b0, 1'b0);
        step();
        drive(1'b0, 4'h7, 1'b1, 1'b1);
        #2;
        chk("R1", "no change before edge", qa, 4'h0);
        chk("R1", "no change before edge sync", qs, 4'h0);
        step();
        chk("R1", "change at edge", qa, 4'h7);
    endtask

    task automatic t_clear();
        drive(1'b0, 4'h9, 1'b0, 1'b0);
        step();
        drive(1'b1, 4'h9, 1'b0, 1'b0);
        @(posedge clk);
        #2;
        clr_n = 1'b0;
        #1;
        chk("R3", "async clear immediate", qa, 4'h0);
        chk("R4", "sync clear waits for edge", qs, 4'h9);
        @(negedge clk);
        chk("R4", "sync clear still pending", qs, 4'h9);
        drive(1'b0, 4'hC, 1'b1, 1'b1);
        step();
        chk("R3", "async clear overrides load", qa, 4'h0);
        chk("R9", "sync clear beats load", qs, 4'h0);
        step();
        chk("R3", "async clear holds over edges", qa, 4'h0);
        clr_n = 1'b1;
        step();
        chk("R2", "load after clear release", qa, 4'hC);
        chk("R2", "load after clear release sync", qs, 4'hC);
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        t_reset();
        t_load();
        t_count();
        t_wrap_carry();
        t_between_edges();
        t_clear();
        done = 1'b1;
        report();
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

endmodule